// File: doc/BRIEF.md
# Request Packet Receive Controller

This block takes request frames one byte at a time from a receive packet queue and decides what each request does. It reads a 14-byte link header and compares the 16-bit frame type against a configured value. It then reads an 8-byte command field and classifies the opcode. A memory-write request streams its payload straight into a local byte-wide memory through a write port. A read or ping request is handed to the transmit side as one (address, opcode) entry on a command FIFO write port.

Frames with a foreign type and requests with an unknown opcode are consumed up to their last byte and have no effect. A frame that ends before its command field is complete is dropped and counted. The input uses a valid/ready byte handshake with an end-of-packet marker. A separate packet-available flag tells the controller that a frame is waiting. The controller holds its input while the command FIFO is full, so no command is lost.

Top module: `rqrx_top`

## Requirements
- R1: After reset, in_ready, mem_we and fifo_we are 0 and err_count is 0.
- R2: While the controller is waiting and pkt_avail is 0, in_ready stays 0 and no byte is consumed, whatever in_valid does.
- R3: Bytes 12 and 13 of a frame form the type, most significant byte first. A frame whose type differs from cfg_etype is consumed to its last byte with no memory write, no FIFO push and no change to err_count.
- R4: Command bytes follow the header. Byte 14 is the opcode, bytes 15 to 17 are ignored, and bytes 18 to 21 are the address, most significant byte first. Opcode 0x01 is a memory write, 0x02 is a read and 0x03 is a ping. Any other opcode makes the frame be discarded with no write and no push.
- R5: For a memory write, payload byte k (byte 22+k of the frame) is written with mem_addr equal to the low MEM_AW bits of address+k. Exactly one write happens per payload byte, and the address wraps modulo 2^MEM_AW.
- R6: A read or ping produces exactly one FIFO push with fifo_data[39:8] = address and fifo_data[7:0] = opcode. Any bytes after the command field are discarded.
- R7: While fifo_full is 1, no push happens and in_ready stays 0. The pending entry is pushed once fifo_full returns to 0.
- R8: A frame with a matching type, or one that ends inside the header, that ends before byte 21 is received adds 1 to err_count and causes no write or push.
- R9: A memory write that ends exactly at byte 21 (no payload) performs no write and leaves err_count unchanged.
- R10: Frames presented back to back are each handled independently, in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_etype | input | 16 | Accepted frame type |
| pkt_avail | input | 1 | A frame is waiting in the receive queue |
| in_valid | input | 1 | in_data holds a byte |
| in_data | input | 8 | Frame byte |
| in_last | input | 1 | in_data is the last byte of the frame |
| in_ready | output | 1 | Controller accepts a byte this cycle |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | MEM_AW | Memory byte address |
| mem_wdata | output | 8 | Memory write data |
| fifo_full | input | 1 | Command FIFO cannot accept an entry |
| fifo_we | output | 1 | Command FIFO push |
| fifo_data | output | 40 | {address, opcode} |
| err_count | output | ERR_W | Truncated-frame count, wrapping |

## Verification
The checker relies on pkt_avail describing the queue honestly and on fifo_full being a level that the FIFO holds until it drains. Under those conditions a push can never follow a full cycle, and frame boundaries are separated by header bytes, so back-to-back memory writes always step the address by one. The bench drives bytes only through the valid/ready handshake and keeps in_valid, in_data and in_last steady until a byte is taken. It raises pkt_avail only while a frame is being offered and moves fifo_full only between frames or while the controller is stalled.

// File: rtl/rqrx_pkg.sv
package rqrx_pkg;
  localparam int HDR_BYTES = 14;
  localparam int CMD_BYTES = 8;
  localparam int IDX_W     = $clog2(HDR_BYTES + CMD_BYTES);
  localparam int TYPE_HI   = HDR_BYTES - 2;
  localparam int TYPE_LO   = HDR_BYTES - 1;
  localparam int OPC_IDX   = HDR_BYTES;
  localparam int ADR_IDX   = HDR_BYTES + 4;
  localparam int CMD_END   = HDR_BYTES + CMD_BYTES - 1;

  localparam logic [7:0] OP_MEMWR = 8'h01;
  localparam logic [7:0] OP_READ  = 8'h02;
  localparam logic [7:0] OP_PING  = 8'h03;

  typedef enum logic [2:0] {
    S_IDLE, S_HDR, S_CMD, S_CHECK, S_DO, S_WMEM, S_FILL, S_DRAIN
  } state_t;
endpackage

// File: rtl/rqrx_decode.sv
module rqrx_decode (
  input  logic [7:0] opcode,
  output logic       known,
  output logic       is_write
);
  import rqrx_pkg::*;
  always_comb begin
    is_write = (opcode == OP_MEMWR);
    known    = is_write || (opcode == OP_READ) || (opcode == OP_PING);
  end
endmodule

// File: rtl/rqrx_field_cap.sv
module rqrx_field_cap #(
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             take,
  input  logic [IDX_W-1:0] idx,
  input  logic [7:0]       din,
  output logic [7:0]       type_hi,
  output logic [7:0]       opcode,
  output logic [31:0]      addr
);
  import rqrx_pkg::*;

  always_ff @(posedge clk) begin
    if (rst) begin
      type_hi <= '0;
      opcode  <= '0;
    end else if (take) begin
      if (idx == IDX_W'(TYPE_HI)) type_hi <= din;
      if (idx == IDX_W'(OPC_IDX)) opcode  <= din;
    end
  end

  for (genvar g = 0; g < 4; g++) begin : g_addr
    always_ff @(posedge clk) begin
      if (rst)
        addr[31-8*g -: 8] <= '0;
      else if (take && idx == IDX_W'(ADR_IDX + g))
        addr[31-8*g -: 8] <= din;
    end
  end
endmodule

// File: rtl/rqrx_err_ctr.sv
module rqrx_err_ctr #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         bump,
  output logic [W-1:0] count
);
  always_ff @(posedge clk) begin
    if (rst)       count <= '0;
    else if (bump) count <= count + 1'b1;
  end
endmodule

// File: rtl/rqrx_top.sv
module rqrx_top #(
  parameter int MEM_AW = 10,
  parameter int ERR_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [15:0]       cfg_etype,
  input  logic              pkt_avail,
  input  logic              in_valid,
  input  logic [7:0]        in_data,
  input  logic              in_last,
  output logic              in_ready,
  output logic              mem_we,
  output logic [MEM_AW-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  input  logic              fifo_full,
  output logic              fifo_we,
  output logic [39:0]       fifo_data,
  output logic [ERR_W-1:0]  err_count
);
  import rqrx_pkg::*;

  state_t            state;
  logic [IDX_W-1:0]  idx;
  logic [MEM_AW-1:0] off;
  logic              eop_seen;
  logic [7:0]        type_hi, opcode;
  logic [31:0]       addr;
  logic              known, is_write;
  logic              take, type_ok, trunc;

  assign in_ready = (state == S_HDR) || (state == S_CMD) ||
                    (state == S_WMEM) || (state == S_DRAIN);
  assign take     = in_valid && in_ready;
  assign type_ok  = ({type_hi, in_data} == cfg_etype);
  assign trunc    = take && in_last &&
                    ((state == S_HDR && (idx != IDX_W'(TYPE_LO) || type_ok)) ||
                     (state == S_CMD && idx != IDX_W'(CMD_END)));

  rqrx_field_cap #(.IDX_W(IDX_W)) u_cap (
    .clk(clk), .rst(rst), .take(take && state != S_WMEM && state != S_DRAIN),
    .idx(idx), .din(in_data), .type_hi(type_hi), .opcode(opcode), .addr(addr)
  );

  rqrx_decode u_dec (.opcode(opcode), .known(known), .is_write(is_write));

  rqrx_err_ctr #(.W(ERR_W)) u_err (
    .clk(clk), .rst(rst), .bump(trunc), .count(err_count)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      idx       <= '0;
      off       <= '0;
      eop_seen  <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      fifo_we   <= 1'b0;
      fifo_data <= '0;
    end else begin
      mem_we  <= 1'b0;
      fifo_we <= 1'b0;
      case (state)
        S_IDLE: begin
          idx      <= '0;
          eop_seen <= 1'b0;
          if (pkt_avail) state <= S_HDR;
        end
        S_HDR: if (take) begin
          idx <= idx + 1'b1;
          if (in_last)                       state <= S_IDLE;
          else if (idx == IDX_W'(TYPE_LO))   state <= type_ok ? S_CMD : S_DRAIN;
        end
        S_CMD: if (take) begin
          idx <= idx + 1'b1;
          if (idx == IDX_W'(CMD_END)) begin
            eop_seen <= in_last;
            state    <= S_CHECK;
          end else if (in_last) begin
            state <= S_IDLE;
          end
        end
        S_CHECK: begin
          if (known)         state <= S_DO;
          else if (eop_seen) state <= S_IDLE;
          else               state <= S_DRAIN;
        end
        S_DO: begin
          off <= '0;
          if (is_write) state <= eop_seen ? S_IDLE : S_WMEM;
          else          state <= S_FILL;
        end
        S_WMEM: if (take) begin
          mem_we    <= 1'b1;
          mem_addr  <= addr[MEM_AW-1:0] + off;
          mem_wdata <= in_data;
          off       <= off + 1'b1;
          if (in_last) state <= S_IDLE;
        end
        S_FILL: if (!fifo_full) begin
          fifo_we   <= 1'b1;
          fifo_data <= {addr, opcode};
          state     <= eop_seen ? S_IDLE : S_DRAIN;
        end
        S_DRAIN: if (take && in_last) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rqrx_chk.sv
module rqrx_chk #(
  parameter int MEM_AW = 10,
  parameter int ERR_W  = 8
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  pkt_avail,
  input logic                  fifo_full,
  input logic                  fifo_we,
  input logic [39:0]           fifo_data,
  input logic                  mem_we,
  input logic [MEM_AW-1:0]     mem_addr,
  input logic [ERR_W-1:0]      err_count,
  input rqrx_pkg::state_t      state
);
  import rqrx_pkg::*;

  assert_leave_idle_R2: assert property (@(posedge clk) disable iff (rst)
    (state == S_HDR && $past(state) == S_IDLE) |-> $past(pkt_avail));

  assert_no_push_full_R7: assert property (@(posedge clk) disable iff (rst)
    fifo_we |-> !$past(fifo_full));

  assert_push_opcode_R6: assert property (@(posedge clk) disable iff (rst)
    fifo_we |-> (fifo_data[7:0] == OP_READ || fifo_data[7:0] == OP_PING));

  assert_addr_step_R5: assert property (@(posedge clk) disable iff (rst)
    (mem_we && $past(mem_we)) |-> mem_addr == $past(mem_addr) + 1'b1);

  assert_err_step_R8: assert property (@(posedge clk) disable iff (rst)
    (err_count == $past(err_count)) || (err_count == $past(err_count) + 1'b1));

  assert_one_port_R10: assert property (@(posedge clk) disable iff (rst)
    $onehot0({mem_we, fifo_we}));
endmodule

bind rqrx_top rqrx_chk #(.MEM_AW(MEM_AW), .ERR_W(ERR_W)) u_chk (
  .clk(clk), .rst(rst), .pkt_avail(pkt_avail), .fifo_full(fifo_full),
  .fifo_we(fifo_we), .fifo_data(fifo_data), .mem_we(mem_we),
  .mem_addr(mem_addr), .err_count(err_count), .state(state)
);

// File: tb/tb_rqrx_top.sv
`timescale 1ns/1ps
module tb_rqrx_top;
  localparam int AW = 10;
  localparam int EW = 8;
  localparam logic [15:0] ETYPE = 16'h88B5;

  logic clk = 0, rst = 1;
  logic pkt_avail = 0, in_valid = 0, in_last = 0, fifo_full = 0;
  logic [7:0] in_data = 0;
  logic in_ready, mem_we, fifo_we;
  logic [AW-1:0] mem_addr;
  logic [7:0] mem_wdata;
  logic [39:0] fifo_data;
  logic [EW-1:0] err_count;

  rqrx_top #(.MEM_AW(AW), .ERR_W(EW)) dut (
    .clk(clk), .rst(rst), .cfg_etype(ETYPE), .pkt_avail(pkt_avail),
    .in_valid(in_valid), .in_data(in_data), .in_last(in_last), .in_ready(in_ready),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .fifo_full(fifo_full), .fifo_we(fifo_we), .fifo_data(fifo_data),
    .err_count(err_count)
  );

  always #2.5 clk = ~clk;

  int checks = 0, fails = 0;
  int exp_err = 0;
  logic [7:0]      pkt[$];
  logic [AW+7:0]   exp_mem[$];
  logic [39:0]     exp_fifo[$];
  bit done = 0;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Per-clock comparison of every output event against the model queues
  always @(negedge clk) if (!rst) begin
    if (mem_we) begin
      if (exp_mem.size() == 0) check("R5 unexpected write", {mem_addr, mem_wdata}, 0);
      else check("R5 write", {mem_addr, mem_wdata}, exp_mem.pop_front());
    end
    if (fifo_we) begin
      if (exp_fifo.size() == 0) check("R6 unexpected push", fifo_data, 0);
      else check("R6 push", fifo_data, exp_fifo.pop_front());
    end
  end

  // Build a frame and predict its effect from the requirements
  task automatic make(input logic [15:0] et, input logic [7:0] op,
                      input logic [31:0] a, input int pay, input int total);
    int len;
    pkt.delete();
    for (int i = 0; i < 12; i++) pkt.push_back(8'(i * 7 + 1));
    pkt.push_back(et[15:8]); pkt.push_back(et[7:0]);
    pkt.push_back(op);
    for (int i = 0; i < 3; i++) pkt.push_back(8'hA5);
    for (int i = 3; i >= 0; i--) pkt.push_back(a[8*i +: 8]);
    for (int i = 0; i < pay; i++) pkt.push_back(8'(i * 13 + 8'h40));
    if (total >= 0) while (pkt.size() > total) void'(pkt.pop_back());
    len = pkt.size();
    if (len < 14) exp_err++;
    else if (et != ETYPE) ;
    else if (len < 22) exp_err++;
    else if (op == 8'h01) begin
      for (int k = 0; k < len - 22; k++)
        exp_mem.push_back({AW'(a + 32'(k)), pkt[22 + k]});
    end else if (op == 8'h02 || op == 8'h03) exp_fifo.push_back({a, op});
  endtask

  task automatic send();
    logic [7:0] b[$];
    bit r;
    b = pkt;
    @(negedge clk);
    pkt_avail = 1;
    for (int i = 0; i < b.size(); i++) begin
      in_valid = 1; in_data = b[i]; in_last = (i == b.size() - 1);
      r = 0;
      while (!r) begin
        r = in_ready;
        @(negedge clk);
      end
    end
    in_valid = 0; in_last = 0; pkt_avail = 0;
    done = 1;
  endtask

  task automatic settle(input string req);
    repeat (8) @(negedge clk);
    check({req, " err_count"}, err_count, exp_err);
    check({req, " writes left"}, exp_mem.size(), 0);
    check({req, " pushes left"}, exp_fifo.size(), 0);
  endtask

  initial begin
    #(5.0 * 150000);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    check("R1 in_ready", in_ready, 0);
    check("R1 mem_we", mem_we, 0);
    check("R1 fifo_we", fifo_we, 0);
    check("R1 err_count", err_count, 0);

    // R2 byte offered without pkt_avail is not taken
    in_valid = 1; in_data = 8'h55;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check("R2 in_ready held low", in_ready, 0);
    end
    in_valid = 0;

    // R5 R4 memory write with ignored reserved bytes
    make(ETYPE, 8'h01, 32'h0000_0100, 4, -1); send(); settle("R5");
    // R3 foreign frame type
    make(16'h0800, 8'h01, 32'h10, 5, -1); send(); settle("R3");
    // R3 foreign type, short but past header: no error
    make(16'h0806, 8'h02, 32'h10, 0, 16); send(); settle("R3 short");
    // R4 unknown opcode with payload
    make(ETYPE, 8'h7E, 32'h20, 3, -1); send(); settle("R4");
    // R6 read with trailing bytes, ping exactly 22 bytes
    make(ETYPE, 8'h02, 32'hDEAD_BEEF, 3, -1); send(); settle("R6 read");
    make(ETYPE, 8'h03, 32'h1234_5678, 0, -1); send(); settle("R6 ping");
    // R8 truncated inside header and inside command
    make(ETYPE, 8'h01, 32'h0, 0, 8); send(); settle("R8 header");
    make(ETYPE, 8'h02, 32'h0, 0, 17); send(); settle("R8 command");
    // R9 write with no payload
    make(ETYPE, 8'h01, 32'h40, 0, -1); send(); settle("R9");
    // R5 address wraps modulo 2^AW
    make(ETYPE, 8'h01, 32'hFFFF_FFFE, 3, -1); send(); settle("R5 wrap");
    // R10 back-to-back frames
    make(ETYPE, 8'h01, 32'h200, 2, -1); send();
    make(ETYPE, 8'h03, 32'hCAFE_0001, 1, -1); send();
    make(ETYPE, 8'h01, 32'h300, 1, -1); send(); settle("R10");

    // R7 stall while the FIFO is full
    fifo_full = 1; done = 0;
    make(ETYPE, 8'h02, 32'hABCD_0000, 4, -1);
    fork send(); join_none
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      check("R7 no push while full", fifo_we, 0);
    end
    check("R7 input held", in_ready, 0);
    check("R7 entry pending", exp_fifo.size(), 1);
    fifo_full = 0;
    wait (done);
    settle("R7");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule